// File: doc/BRIEF.md
# Counter CSR Access Exception Classifier

This block judges a single attempt by a hart with hypervisor support to read a user-level counter CSR, or to run a hypervisor load, store or fence instruction. It takes the current privilege level, the virtualization bit, the XLEN mode, the CSR address and the three counter-enable registers (machine, hypervisor and supervisor). It returns one of three verdicts: allow, raise an illegal instruction exception, or raise a virtual instruction exception.

The decision itself is combinational. It then passes through an output stage that a parameter selects. The stage is either one register, which is the default and gives one cycle of latency, or a plain wire. One rule matters most. In virtual user mode, a counter that only the supervisor enable register blocks raises a virtual instruction exception and not an illegal one. The reason is that the access would be legal in HS-mode, and the guest kernel is the one that should handle it.

Privilege is encoded as 2'b11 machine, 2'b01 supervisor, 2'b00 user and 2'b10 reserved. Together with the virtualization bit this gives the modes M, HS, U, VS (supervisor with V=1) and VU (user with V=1). The V bit is ignored in machine mode. The output is coded as {exc_virtual, exc_illegal}: 00 allow, 01 illegal, 10 virtual.

Top module: `ctr_access_judge`

## Requirements
- R1: While acc_valid is 0, both exception outputs are 0, whatever the other inputs are.
- R2: In M-mode, and in HS-mode (supervisor with V=0), an access to a counter address that is valid for the current XLEN is allowed whatever the enable bits are.
- R3: With xlen32=0, an access to the high window 0xC80 to 0xC9F raises an illegal instruction exception in every mode, including M-mode.
- R4: In U, VS and VU modes, an access to counter index i with mcounteren bit i at 0 raises an illegal instruction exception. This rule takes priority over every virtual instruction rule.
- R5: In U-mode (V=0) with mcounteren bit i at 1, scounteren bit i at 0 gives illegal and 1 gives allow. The hcounteren bit is ignored.
- R6: In VS-mode with mcounteren bit i at 1, hcounteren bit i at 0 gives a virtual instruction exception and 1 gives allow. The scounteren bit is ignored.
- R7: In VU-mode with mcounteren bit i at 1, a 0 in either hcounteren bit i or scounteren bit i gives a virtual instruction exception. If both bits are 1 the access is allowed.
- R8: The low window 0xC00 to 0xC1F maps to index addr-0xC00. With xlen32=1, the high window 0xC80 to 0xC9F maps to index addr-0xC80 and follows the same rules as the low window.
- R9: With hyp_insn=1 the CSR address and the enable registers are ignored. VS and VU give virtual, M and HS give allow, and U-mode and the reserved level give illegal.
- R10: A CSR address outside both counter windows raises no exception.
- R11: The reserved privilege code 2'b10 gives illegal for a counter access. In M-mode the virt_on bit has no effect.
- R12: With REG_OUT=1 the verdict appears one clock after the inputs that produced it. Reset clears the verdict to allow, and the two outputs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the verdict to allow |
| priv_lvl | input | 2 | Privilege level: 11 M, 01 S, 00 U, 10 reserved |
| virt_on | input | 1 | Virtualization bit V |
| xlen32 | input | 1 | 1 when the hart runs with XLEN=32 |
| csr_addr | input | 12 | Address of the CSR being accessed |
| acc_valid | input | 1 | The inputs hold an attempt to be judged |
| hyp_insn | input | 1 | The attempt is a hypervisor load, store or fence, not a CSR access |
| m_cnt_en | input | 32 | Machine counter-enable register |
| h_cnt_en | input | 32 | Hypervisor counter-enable register |
| s_cnt_en | input | 32 | Supervisor counter-enable register |
| exc_illegal | output | 1 | Raise an illegal instruction exception |
| exc_virtual | output | 1 | Raise a virtual instruction exception |

## Verification
Some behaviours are checked by assertions on every cycle:
- idle attempts stay quiet;
- a high-window access under 64-bit XLEN is always illegal;
- the machine enable gate takes priority;
- a VU-mode access blocked only by the supervisor register is virtual;
- a hypervisor instruction under V=1 is virtual;
- M and HS access is always allowed.

Other behaviours are shown only by the bench's scenarios:
- the mapping from address to index in both windows;
- that bits other than the selected one have no effect;
- addresses outside the windows;
- the reserved privilege code;
- the one-cycle output latency and the reset value.

For this, the bench sweeps every mode against all eight enable combinations at three counter indices.

// File: rtl/ctr_judge_pkg.sv
package ctr_judge_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    VERD_ALLOW   = 2'b00,
    VERD_ILLEGAL = 2'b01,
    VERD_VIRTUAL = 2'b10
  } verdict_e;

  typedef enum logic [2:0] {
    MODE_M   = 3'd0,
    MODE_HS  = 3'd1,
    MODE_U   = 3'd2,
    MODE_VS  = 3'd3,
    MODE_VU  = 3'd4,
    MODE_BAD = 3'd5
  } mode_e;

  // Fold privilege code and V bit into one effective mode.
  function automatic mode_e mode_of(logic [1:0] priv, logic virt);
    mode_e m;
    case (priv)
      PRIV_M:  m = MODE_M;
      PRIV_S:  m = virt ? MODE_VS : MODE_HS;
      PRIV_U:  m = virt ? MODE_VU : MODE_U;
      default: m = MODE_BAD;
    endcase
    return m;
  endfunction

  // Verdict for a counter CSR access that hit one of the windows.
  function automatic verdict_e judge_counter(mode_e m, logic high_bad,
                                             logic m_bit, logic h_bit,
                                             logic s_bit);
    verdict_e v;
    if (high_bad) begin
      v = VERD_ILLEGAL;
    end else begin
      case (m)
        MODE_M, MODE_HS: v = VERD_ALLOW;
        MODE_U:  v = !m_bit ? VERD_ILLEGAL : (s_bit ? VERD_ALLOW : VERD_ILLEGAL);
        MODE_VS: v = !m_bit ? VERD_ILLEGAL : (h_bit ? VERD_ALLOW : VERD_VIRTUAL);
        MODE_VU: v = !m_bit ? VERD_ILLEGAL :
                     ((h_bit && s_bit) ? VERD_ALLOW : VERD_VIRTUAL);
        default: v = VERD_ILLEGAL;
      endcase
    end
    return v;
  endfunction

  // Verdict for a hypervisor load/store/fence instruction.
  function automatic verdict_e judge_hyp(mode_e m);
    verdict_e v;
    case (m)
      MODE_VS, MODE_VU: v = VERD_VIRTUAL;
      MODE_M, MODE_HS:  v = VERD_ALLOW;
      default:          v = VERD_ILLEGAL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode #(
  parameter int ADDR_W = 12,
  parameter int NUM_CTR = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 12'hC80,
  localparam int IDX_W = $clog2(NUM_CTR)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_low,
  output logic              hit_high,
  output logic [IDX_W-1:0]  idx
);

  logic [ADDR_W-1:0] off_low;
  logic [ADDR_W-1:0] off_high;

  assign off_low  = addr - LOW_BASE;
  assign off_high = addr - HIGH_BASE;

  // Unsigned wrap makes addresses below a base fall outside its window.
  assign hit_low  = off_low  < ADDR_W'(NUM_CTR);
  assign hit_high = off_high < ADDR_W'(NUM_CTR);

  assign idx = hit_high ? off_high[IDX_W-1:0] : off_low[IDX_W-1:0];

endmodule

// File: rtl/ctr_enable_pick.sv
module ctr_enable_pick #(
  parameter int NUM_CTR = 32,
  localparam int IDX_W = $clog2(NUM_CTR)
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_CTR-1:0] m_en,
  input  logic [NUM_CTR-1:0] h_en,
  input  logic [NUM_CTR-1:0] s_en,
  output logic               m_bit,
  output logic               h_bit,
  output logic               s_bit
);

  // Same selection repeated for each of the three enable registers.
  logic [2:0]         picked;
  logic [NUM_CTR-1:0] regs [3];

  assign regs[0] = m_en;
  assign regs[1] = h_en;
  assign regs[2] = s_en;

  for (genvar g = 0; g < 3; g++) begin : g_pick
    assign picked[g] = regs[g][idx];
  end

  assign m_bit = picked[0];
  assign h_bit = picked[1];
  assign s_bit = picked[2];

endmodule

// File: rtl/ctr_verdict_core.sv
module ctr_verdict_core
  import ctr_judge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       hyp_insn,
  input  logic [1:0] priv_lvl,
  input  logic       virt_on,
  input  logic       xlen32,
  input  logic       hit_low,
  input  logic       hit_high,
  input  logic       m_bit,
  input  logic       h_bit,
  input  logic       s_bit,
  output verdict_e   verdict
);

  mode_e mode;
  logic  counter_hit;
  logic  high_bad;
  logic  below_hs;

  assign mode        = mode_of(priv_lvl, virt_on);
  assign counter_hit = hit_low | hit_high;
  assign high_bad    = hit_high & ~xlen32;
  assign below_hs    = (mode == MODE_U) || (mode == MODE_VS) || (mode == MODE_VU);

  always_comb begin
    if (!acc_valid)        verdict = VERD_ALLOW;
    else if (hyp_insn)     verdict = judge_hyp(mode);
    else if (!counter_hit) verdict = VERD_ALLOW;
    else                   verdict = judge_counter(mode, high_bad, m_bit, h_bit, s_bit);
  end

  // R1
  a_r1_idle_allows: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> verdict == VERD_ALLOW);

  // R3
  a_r3_high_on_64: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hyp_insn && hit_high && !xlen32) |-> verdict == VERD_ILLEGAL);

  // R4
  a_r4_machine_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hyp_insn && counter_hit && !high_bad && below_hs && !m_bit)
      |-> verdict == VERD_ILLEGAL);

  // R7
  a_r7_vu_sup_block: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hyp_insn && counter_hit && !high_bad && priv_lvl == 2'b00 &&
     virt_on && m_bit && h_bit && !s_bit) |-> verdict == VERD_VIRTUAL);

  // R9
  a_r9_hyp_under_v: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hyp_insn && virt_on && (priv_lvl == 2'b00 || priv_lvl == 2'b01))
      |-> verdict == VERD_VIRTUAL);

  // R2
  a_r2_top_modes_allow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hyp_insn && counter_hit && !high_bad &&
     (priv_lvl == 2'b11 || (priv_lvl == 2'b01 && !virt_on))) |-> verdict == VERD_ALLOW);

endmodule

// File: rtl/ctr_out_stage.sv
module ctr_out_stage
  import ctr_judge_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_e verdict,
  output logic     exc_illegal,
  output logic     exc_virtual
);

  verdict_e held;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= VERD_ALLOW;
      else        held <= verdict;
    end
  end else begin : g_wire
    assign held = verdict;
  end

  assign exc_illegal = (held == VERD_ILLEGAL);
  assign exc_virtual = (held == VERD_VIRTUAL);

  // R12
  a_r12_one_exception: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_illegal && exc_virtual));

endmodule

// File: rtl/ctr_access_judge.sv
module ctr_access_judge
  import ctr_judge_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CTR = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 12'hC80,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_lvl,
  input  logic               virt_on,
  input  logic               xlen32,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic               acc_valid,
  input  logic               hyp_insn,
  input  logic [NUM_CTR-1:0] m_cnt_en,
  input  logic [NUM_CTR-1:0] h_cnt_en,
  input  logic [NUM_CTR-1:0] s_cnt_en,
  output logic               exc_illegal,
  output logic               exc_virtual
);

  logic             hit_low;
  logic             hit_high;
  logic [IDX_W-1:0] idx;
  logic             m_bit;
  logic             h_bit;
  logic             s_bit;
  verdict_e         verdict;

  ctr_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR),
    .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
  ) u_decode (
    .addr(csr_addr), .hit_low(hit_low), .hit_high(hit_high), .idx(idx)
  );

  ctr_enable_pick #(.NUM_CTR(NUM_CTR)) u_pick (
    .idx(idx), .m_en(m_cnt_en), .h_en(h_cnt_en), .s_en(s_cnt_en),
    .m_bit(m_bit), .h_bit(h_bit), .s_bit(s_bit)
  );

  ctr_verdict_core u_core (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .hyp_insn(hyp_insn),
    .priv_lvl(priv_lvl), .virt_on(virt_on), .xlen32(xlen32),
    .hit_low(hit_low), .hit_high(hit_high),
    .m_bit(m_bit), .h_bit(h_bit), .s_bit(s_bit), .verdict(verdict)
  );

  ctr_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .verdict(verdict),
    .exc_illegal(exc_illegal), .exc_virtual(exc_virtual)
  );

  if (REG_OUT) begin : g_reg_checks
    // R1: an idle cycle leaves the registered outputs quiet one cycle later
    a_r1_idle_quiet_next: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!exc_illegal && !exc_virtual));
    // R12: a machine-mode hypervisor instruction reads as allow one cycle later
    a_r12_latency_m_hyp: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && hyp_insn && priv_lvl == 2'b11) |=> (!exc_illegal && !exc_virtual));
  end

endmodule

// File: tb/ctr_access_judge_bench.sv
module ctr_access_judge_bench;

  localparam int MD_M = 0, MD_HS = 1, MD_U = 2, MD_VS = 3, MD_VU = 4, MD_RSV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_lvl = 2'b11;
  logic        virt_on = 1'b0;
  logic        xlen32 = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic        acc_valid = 1'b0;
  logic        hyp_insn = 1'b0;
  logic [31:0] m_cnt_en = '0;
  logic [31:0] h_cnt_en = '0;
  logic [31:0] s_cnt_en = '0;
  logic        exc_illegal;
  logic        exc_virtual;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ctr_access_judge u_ctr_access_judge (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .virt_on(virt_on),
    .xlen32(xlen32), .csr_addr(csr_addr), .acc_valid(acc_valid),
    .hyp_insn(hyp_insn), .m_cnt_en(m_cnt_en), .h_cnt_en(h_cnt_en),
    .s_cnt_en(s_cnt_en), .exc_illegal(exc_illegal), .exc_virtual(exc_virtual)
  );

  function automatic void set_mode(int md);
    case (md)
      MD_M:    begin priv_lvl = 2'b11; virt_on = 1'b0; end
      MD_HS:   begin priv_lvl = 2'b01; virt_on = 1'b0; end
      MD_U:    begin priv_lvl = 2'b00; virt_on = 1'b0; end
      MD_VS:   begin priv_lvl = 2'b01; virt_on = 1'b1; end
      MD_VU:   begin priv_lvl = 2'b00; virt_on = 1'b1; end
      default: begin priv_lvl = 2'b10; virt_on = 1'b0; end
    endcase
  endfunction

  // Expected code {virtual, illegal}: 0 allow, 1 illegal, 2 virtual.
  function automatic int expect_code(int md, bit x32, logic [11:0] a, bit hyp,
                                     logic [31:0] me, logic [31:0] he, logic [31:0] se);
    bit in_lo, in_hi;
    int i;
    if (hyp) begin
      if (md == MD_VS || md == MD_VU) return 2;
      return (md == MD_M || md == MD_HS) ? 0 : 1;
    end
    in_lo = (a >= 12'hC00) && (a <= 12'hC1F);
    in_hi = (a >= 12'hC80) && (a <= 12'hC9F);
    if (!in_lo && !in_hi) return 0;
    if (in_hi && !x32) return 1;
    if (md == MD_RSV) return 1;
    if (md == MD_M || md == MD_HS) return 0;
    i = int'(a[4:0]);
    if (me[i] == 1'b0) return 1;
    if (md == MD_U) return se[i] ? 0 : 1;
    if (md == MD_VS) return he[i] ? 0 : 2;
    return (he[i] && se[i]) ? 0 : 2;
  endfunction

  function automatic string sweep_tag(int md, bit x32, logic [11:0] a, logic [31:0] me);
    bit in_hi = (a >= 12'hC80);
    if (in_hi && !x32) return "R3";
    if (md == MD_RSV) return "R11";
    if (md == MD_M || md == MD_HS) return "R2";
    if (me[a[4:0]] == 1'b0) return "R4";
    if (in_hi) return "R8";
    if (md == MD_U) return "R5";
    if (md == MD_VS) return "R6";
    return "R7";
  endfunction

  task automatic check_out(string tag, int exp);
    int got;
    got = {30'd0, exc_virtual, exc_illegal};
    checks++;
    if (got != exp || (exc_virtual && exc_illegal)) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (mode priv=%b v=%b addr=%h)",
               tag, got, exp, priv_lvl, virt_on, csr_addr);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
  task automatic drive(int md, bit x32, logic [11:0] a, bit vld, bit hyp,
                       logic [31:0] me, logic [31:0] he, logic [31:0] se);
    @(negedge clk);
    set_mode(md);
    xlen32 = x32; csr_addr = a; acc_valid = vld; hyp_insn = hyp;
    m_cnt_en = me; h_cnt_en = he; s_cnt_en = se;
    @(negedge clk);
  endtask

  task automatic t_reset();
    // R12: outputs stay allow while reset holds, even with a blocking attempt present
    set_mode(MD_U); acc_valid = 1'b1; csr_addr = 12'hC02; m_cnt_en = '0;
    repeat (3) @(negedge clk);
    check_out("R12 reset", 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    for (int md = 0; md < 6; md++) begin
      drive(md, 1'b0, 12'hC85, 1'b0, 1'b0, '0, '0, '0);
      check_out("R1 idle", 0);
      drive(md, 1'b1, 12'hC03, 1'b0, 1'b1, '0, '0, '0);
      check_out("R1 idle hyp", 0);
    end
  endtask

  task automatic t_sweep();
    int idxs[3] = '{0, 2, 31};
    for (int k = 0; k < 3; k++) begin
      for (int hi = 0; hi < 2; hi++) begin
        for (int x = 0; x < 2; x++) begin
          for (int md = 0; md < 6; md++) begin
            for (int c = 0; c < 8; c++) begin
              logic [31:0] one, me, he, se;
              logic [11:0] a;
              one = 32'd1 << idxs[k];
              me = c[0] ? one : ~one;
              he = c[1] ? one : ~one;
              se = c[2] ? one : ~one;
              a = (hi != 0 ? 12'hC80 : 12'hC00) + 12'(idxs[k]);
              drive(md, x[0], a, 1'b1, 1'b0, me, he, se);
              check_out(sweep_tag(md, x[0], a, me),
                        expect_code(md, x[0], a, 1'b0, me, he, se));
            end
          end
        end
      end
    end
  endtask

  task automatic t_hyp();
    for (int md = 0; md < 6; md++) begin
      drive(md, 1'b1, 12'hC01, 1'b1, 1'b1, '1, '1, '1);
      check_out("R9 hyp", expect_code(md, 1'b1, 12'hC01, 1'b1, '1, '1, '1));
      drive(md, 1'b0, 12'hC90, 1'b1, 1'b1, '0, '0, '0);
      check_out("R9 hyp ignores csr", expect_code(md, 1'b0, 12'hC90, 1'b1, '0, '0, '0));
    end
  endtask

  task automatic t_outside();
    logic [11:0] addrs[6] = '{12'hBFF, 12'hC20, 12'hC7F, 12'hCA0, 12'h000, 12'hFFF};
    for (int j = 0; j < 6; j++) begin
      drive(MD_VU, 1'b0, addrs[j], 1'b1, 1'b0, '0, '0, '0);
      check_out("R10 outside", 0);
    end
  endtask

  task automatic t_reserved();
    drive(MD_RSV, 1'b1, 12'hC00, 1'b1, 1'b0, '1, '1, '1);
    check_out("R11 reserved", 1);
    @(negedge clk);
    priv_lvl = 2'b11; virt_on = 1'b1; xlen32 = 1'b1; csr_addr = 12'hC05;
    acc_valid = 1'b1; hyp_insn = 1'b0; m_cnt_en = '0; h_cnt_en = '0; s_cnt_en = '0;
    @(negedge clk);
    check_out("R11 M ignores V", 0);
  endtask

  task automatic t_latency();
    drive(MD_M, 1'b1, 12'hC00, 1'b1, 1'b0, '1, '1, '1);
    check_out("R12 setup", 0);
    @(negedge clk);
    set_mode(MD_VS); h_cnt_en = '0;
    #2;
    check_out("R12 before edge", 0);
    @(negedge clk);
    check_out("R12 after edge", 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_sweep();
    t_hyp();
    t_outside();
    t_reserved();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule